// File: doc/BRIEF.md
# Extended Match Timer Bank

This block holds eight extended timer channels, numbered 4 to 11. It sits next to a base timer on a shared register bus. Each channel has a counter, a match register and a control register. The control register sets four things for the channel: which prescaled tick advances its counter, whether a match clears that counter, whether the channel stays armed after a match, and whether the channel compares against its own counter or against the counter of its group leader. Channel 4 leads channels 4 to 7, channel 8 leads channels 8 and 9, and channel 10 leads channels 10 and 11.

The tick rates are produced outside the block. They arrive as single-cycle enables on `tick_i`. A match sets a sticky event bit, provided the matching channel's enable bit is set. The event bits and the enable mask belong to a status register shared with the base timer, so they cross the block edge as `status_o`, `irq_en_i` and `status_clr_i`. The eight channels drive one interrupt line. Channels 9 and 11 can also be set up so that reading their counter latches the neighbouring counter into a snapshot register, which lets software capture a consistent pair of counts.

Top module: `ext_match_bank`

## Requirements
- R1: After synchronous reset, every counter, match, control and snapshot register reads 0, and `status_o`, `irq_o` and `bus_rdata_o` are 0.
- R2: Control bits [2:0] pick the rate that advances a counter by one per cycle. Value k from 1 to 5 follows `tick_i[k-1]` (bit 0 is 32.768 kHz, bit 1 is 1 kHz, bit 2 is 1 Hz, bit 3 is 1 MHz, bit 4 is external). Values 0, 6 and 7 stop the counter.
- R3: A counter write loads the value at that clock edge and takes priority over a tick in the same cycle.
- R4: A channel matches in the cycle its reference counter steps from match−1 to the match value while the channel is armed. The event bit for channel n is `status_o[n-4]`, and it is set at that edge.
- R5: With control bit 3 set, a match loads the channel's own counter with 0 instead of the stepped value.
- R6: With control bit 6 set, the channel stays armed after a match. With bit 6 clear, a match disarms the channel. Writing the channel's match or control register arms it again.
- R7: With control bit 7 clear, channels 5 to 7 compare against channel 4's counter, channel 9 against channel 8's, and channel 11 against channel 10's, and their own counters hold. Channels 4, 8 and 10 always run their own counter.
- R8: Control writes keep bits [7:0] for channels 4 to 7 and bits [9:0] for channels 8 to 11. On channels 8 to 11, bit 8 stops the counter.
- R9: Reading the counter of channel 9 (offset 0x54) or channel 11 (offset 0x5C) while its control bit 9 is set copies the counter of channel 8 or channel 10 into the snapshot register at offset 0x20.
- R10: Event bits stay set until the matching `status_clr_i` bit is pulsed, and a new match in the same cycle wins over the clear. `irq_o` is registered high exactly while any event bit is set.
- R11: Register map: counter of channel n at 0x40+4(n−4), match at 0x80+4(n−4), control at 0xC0+4(n−4), snapshot at 0x20. `bus_rdata_o` carries the addressed value one cycle after `bus_rd_i`. It is 0 for unmapped offsets and for cycles with no read.
- R12: A match on channel n leaves `status_o[n-4]` clear when `irq_en_i[n-4]` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Registered read data |
| tick_i | input | NTICK | Prescaled rate enables and external tick |
| irq_en_i | input | 8 | Enable mask for channels 4..11 (bit 0 = channel 4) |
| status_clr_i | input | 8 | Clear pulses for event bits |
| status_o | output | 8 | Event bits for channels 4..11 |
| irq_o | output | 1 | Shared interrupt |

## Verification
A match can set an event bit in the same cycle that software clears it. The bench provokes this by pulsing the clear and the final tick together. It expects the bit, and the interrupt, to remain set, then expects both to drop after a clear issued on its own. A counter write can also coincide with a tick. The bench provokes this on a running channel and requires the written value, not the written value plus one. A seeded random phase sweeps every rate code against random tick patterns and compares the resulting counts with a bench model.

// File: rtl/ext_tmr_pkg.sv
package ext_tmr_pkg;
  localparam int NCH   = 8;
  localparam int CTL_W = 10;
  localparam int SEL_W = 3;

  // address regions, taken from offset bits [7:5]
  localparam logic [2:0] RGN_SNAP = 3'b001;
  localparam logic [2:0] RGN_CNT  = 3'b010;
  localparam logic [2:0] RGN_MAT  = 3'b100;
  localparam logic [2:0] RGN_CTL  = 3'b110;

  // control bit positions
  localparam int CB_CLR  = 3;
  localparam int CB_PER  = 6;
  localparam int CB_OWN  = 7;
  localparam int CB_HALT = 8;
  localparam int CB_SNAP = 9;

  typedef logic [CTL_W-1:0] ctrl_t;

  // group leader of each channel slot
  function automatic int leader_of(input int slot);
    if (slot < 4)      return 0;
    else if (slot < 6) return 4;
    else               return 6;
  endfunction
endpackage

// File: rtl/ext_tmr_rate_sel.sv
module ext_tmr_rate_sel #(
  parameter int NTICK = 5,
  parameter int SEL_W = 3
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [NTICK-1:0] tick,
  output logic             hit
);
  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NTICK; k++) begin
      if (int'(sel) == k + 1) hit = tick[k];
    end
  end
endmodule

// File: rtl/ext_tmr_chan.sv
module ext_tmr_chan #(
  parameter int CNT_W    = 32,
  parameter bit IS_LEAD  = 1'b0,
  parameter bit HAS_HALT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             c_own,
  input  logic             c_clr,
  input  logic             c_per,
  input  logic             c_halt,
  input  logic             tick_hit,
  input  logic [CNT_W-1:0] ref_cnt,
  input  logic             ref_adv,
  input  logic             cnt_we,
  input  logic             mat_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] mat_o,
  output logic             adv_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, mat_q;
  logic             armed_q;
  logic             runs;

  assign runs    = (c_own || IS_LEAD) && !(HAS_HALT && c_halt);
  assign adv_o   = runs && tick_hit;
  assign match_o = armed_q && ref_adv && ((ref_cnt + 1'b1) == mat_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      mat_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (cnt_we)                cnt_q <= wdata;
      else if (match_o && c_clr) cnt_q <= '0;
      else if (adv_o)            cnt_q <= cnt_q + 1'b1;

      if (mat_we) mat_q <= wdata;

      if (mat_we || ctl_we)      armed_q <= 1'b1;
      else if (match_o && !c_per) armed_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign mat_o = mat_q;
endmodule

// File: rtl/ext_match_bank.sv
module ext_match_bank #(
  parameter int CNT_W = 32,
  parameter int NTICK = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [7:0]       bus_addr_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  input  logic [NTICK-1:0] tick_i,
  input  logic [7:0]       irq_en_i,
  input  logic [7:0]       status_clr_i,
  output logic [7:0]       status_o,
  output logic             irq_o
);
  import ext_tmr_pkg::*;

  logic [2:0] rgn, slot;
  logic       aligned;
  assign rgn     = bus_addr_i[7:5];
  assign slot    = bus_addr_i[4:2];
  assign aligned = (bus_addr_i[1:0] == 2'b00);

  ctrl_t                      ctrl_q [NCH];
  logic [NCH-1:0][CNT_W-1:0]  cnt_w;
  logic [CNT_W-1:0]           mat_w  [NCH];
  logic                       adv_w  [NCH];
  logic [NCH-1:0]             match_w;
  logic [CNT_W-1:0]           snap_q;
  logic [7:0]                 stat_q;
  logic [7:0]                 stat_nx;
  logic                       irq_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int LEAD = leader_of(g);
    logic             hit, cnt_we, mat_we, ctl_we, r_adv;
    logic [CNT_W-1:0] r_cnt;

    assign cnt_we = bus_wr_i && aligned && rgn == RGN_CNT && slot == 3'(g);
    assign mat_we = bus_wr_i && aligned && rgn == RGN_MAT && slot == 3'(g);
    assign ctl_we = bus_wr_i && aligned && rgn == RGN_CTL && slot == 3'(g);
    assign r_cnt  = ctrl_q[g][CB_OWN] ? cnt_w[g] : cnt_w[LEAD];
    assign r_adv  = ctrl_q[g][CB_OWN] ? adv_w[g] : adv_w[LEAD];

    ext_tmr_rate_sel #(.NTICK(NTICK), .SEL_W(SEL_W)) u_rate (
      .sel(ctrl_q[g][SEL_W-1:0]), .tick(tick_i), .hit(hit));

    ext_tmr_chan #(.CNT_W(CNT_W), .IS_LEAD(LEAD == g), .HAS_HALT(g >= 4)) u_chan (
      .clk(clk), .rst(rst),
      .c_own(ctrl_q[g][CB_OWN]), .c_clr(ctrl_q[g][CB_CLR]),
      .c_per(ctrl_q[g][CB_PER]), .c_halt(ctrl_q[g][CB_HALT]),
      .tick_hit(hit), .ref_cnt(r_cnt), .ref_adv(r_adv),
      .cnt_we(cnt_we), .mat_we(mat_we), .ctl_we(ctl_we),
      .wdata(bus_wdata_i), .cnt_o(cnt_w[g]), .mat_o(mat_w[g]),
      .adv_o(adv_w[g]), .match_o(match_w[g]));

    always_ff @(posedge clk) begin
      if (rst)         ctrl_q[g] <= '0;
      else if (ctl_we) begin
        if (g < 4) ctrl_q[g] <= {2'b00, bus_wdata_i[7:0]};
        else       ctrl_q[g] <= bus_wdata_i[CTL_W-1:0];
      end
    end
  end

  assign stat_nx = (stat_q & ~status_clr_i) | (match_w & irq_en_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_nx;
      irq_q  <= |stat_nx;
    end
  end

  // snapshot of the lower neighbour on a counter read of slot 5 or 7
  always_ff @(posedge clk) begin
    if (rst) snap_q <= '0;
    else if (bus_rd_i && aligned && rgn == RGN_CNT && slot[0] && slot[2]
             && ctrl_q[slot][CB_SNAP])
      snap_q <= cnt_w[slot - 3'd1];
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd_i || !aligned) bus_rdata_o <= '0;
    else begin
      unique case (rgn)
        RGN_CNT:  bus_rdata_o <= cnt_w[slot];
        RGN_MAT:  bus_rdata_o <= mat_w[slot];
        RGN_CTL:  bus_rdata_o <= CNT_W'(ctrl_q[slot]);
        RGN_SNAP: bus_rdata_o <= (slot == 3'd0) ? snap_q : '0;
        default:  bus_rdata_o <= '0;
      endcase
    end
  end

  assign status_o = stat_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/ext_match_bank_chk.sv
module ext_match_bank_chk #(
  parameter int CNT_W = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     bus_wr_i,
  input logic                     bus_rd_i,
  input logic [7:0]               bus_addr_i,
  input logic [CNT_W-1:0]         bus_wdata_i,
  input logic [CNT_W-1:0]         bus_rdata_o,
  input logic [7:0]               irq_en_i,
  input logic [7:0]               status_clr_i,
  input logic [7:0]               status_o,
  input logic                     irq_o,
  input logic [7:0][CNT_W-1:0]    cnt_w
);
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_i |=> bus_rdata_o == '0);

  a_r3_cnt_load: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_i && bus_addr_i[7:5] == 3'b010 && bus_addr_i[1:0] == 2'b00)
    |=> cnt_w[$past(bus_addr_i[4:2])] == $past(bus_wdata_i));

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (status_o != '0) |=> ((~status_o & $past(status_o & ~status_clr_i)) == '0));

  a_r12_masked: assert property (@(posedge clk) disable iff (rst)
    ((~irq_en_i & ~status_o) != '0)
    |=> ((status_o & $past(~irq_en_i & ~status_o)) == '0));

  a_r10_irq_raise: assert property (@(posedge clk) disable iff (rst)
    (status_o != '0 && status_clr_i == '0) |=> irq_o);

  a_r10_irq_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_o) |-> status_o == '0);
endmodule

bind ext_match_bank ext_match_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
  .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .irq_en_i(irq_en_i), .status_clr_i(status_clr_i), .status_o(status_o),
  .irq_o(irq_o), .cnt_w(cnt_w));

// File: tb/ext_match_bank_bench.sv
module ext_match_bank_bench;
  localparam int CNT_W = 32;
  localparam int NTICK = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bus_wr_i = 1'b0, bus_rd_i = 1'b0;
  logic [7:0]       bus_addr_i = '0;
  logic [CNT_W-1:0] bus_wdata_i = '0;
  logic [CNT_W-1:0] bus_rdata_o;
  logic [NTICK-1:0] tick_i = '0;
  logic [7:0]       irq_en_i = 8'hFF;
  logic [7:0]       status_clr_i = '0;
  logic [7:0]       status_o;
  logic             irq_o;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  ext_match_bank #(.CNT_W(CNT_W), .NTICK(NTICK)) u_ext_match_bank (.*);

  function automatic logic [7:0] a_cnt(int ch); return 8'(8'h40 + 4 * (ch - 4)); endfunction
  function automatic logic [7:0] a_mat(int ch); return 8'(8'h80 + 4 * (ch - 4)); endfunction
  function automatic logic [7:0] a_ctl(int ch); return 8'(8'hC0 + 4 * (ch - 4)); endfunction
  function automatic int adv_of(int r, logic [4:0] t);
    return (r >= 1 && r <= 5) ? int'(t[r-1]) : 0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk); bus_wr_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd_i = 1'b1; bus_addr_i = a;
    @(negedge clk); bus_rd_i = 1'b0; d = bus_rdata_o;
  endtask

  task automatic tk(logic [4:0] m, logic [7:0] c);
    @(negedge clk); tick_i = m; status_clr_i = c;
    @(negedge clk); tick_i = '0; status_clr_i = '0;
  endtask

  task automatic quiet();
    for (int c = 4; c < 12; c++) wr(a_ctl(c), 32'h0);
    tk(5'h0, 8'hFF);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] v;
    int exp_c;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 status", 32'(status_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    rd(a_cnt(4), v); chk("R1 counter", v, 0);
    rd(a_mat(9), v); chk("R1 match", v, 0);
    rd(a_ctl(11), v); chk("R1 control", v, 0);
    rd(8'h20, v); chk("R1 snapshot", v, 0);

    // R2 rate selection
    wr(a_ctl(4), 32'h1);
    repeat (3) tk(5'h01, 0);
    repeat (2) tk(5'h02, 0);
    rd(a_cnt(4), v); chk("R2 rate1", v, 3);
    wr(a_ctl(4), 32'h4);
    repeat (2) tk(5'h08, 0);
    tk(5'h01, 0);
    rd(a_cnt(4), v); chk("R2 rate4", v, 5);
    wr(a_ctl(4), 32'h6);
    tk(5'h1F, 0);
    rd(a_cnt(4), v); chk("R2 code6 stopped", v, 5);

    // R3 load, and load wins over a tick in the same cycle
    wr(a_ctl(4), 32'h1);
    @(negedge clk); bus_wr_i = 1'b1; bus_addr_i = a_cnt(4); bus_wdata_i = 32'h100; tick_i = 5'h01;
    @(negedge clk); bus_wr_i = 1'b0; tick_i = '0;
    rd(a_cnt(4), v); chk("R3 load over tick", v, 32'h100);

    // R4 match and R10 interrupt
    quiet();
    wr(a_ctl(4), 32'h81); wr(a_mat(4), 32'h10); wr(a_cnt(4), 32'h0E);
    tk(5'h01, 0);
    chk("R4 no early match", 32'(status_o), 0);
    tk(5'h01, 0);
    chk("R4 match status", 32'(status_o), 32'h01);
    chk("R10 irq high", 32'(irq_o), 1);
    rd(a_cnt(4), v); chk("R4 counter kept", v, 32'h10);
    tk(5'h01, 0);
    chk("R10 sticky", 32'(status_o), 32'h01);
    tk(5'h00, 8'h01);
    chk("R10 cleared", 32'(status_o), 0);
    chk("R10 irq low", 32'(irq_o), 0);

    // R12 masked match
    irq_en_i = 8'hFE;
    wr(a_mat(4), 32'h20); wr(a_cnt(4), 32'h1F);
    tk(5'h01, 0);
    chk("R12 masked status", 32'(status_o), 0);
    chk("R12 masked irq", 32'(irq_o), 0);
    irq_en_i = 8'hFF;

    // R10 set and clear in the same cycle
    wr(a_mat(4), 32'h30); wr(a_cnt(4), 32'h2F);
    tk(5'h01, 8'h01);
    chk("R10 set wins", 32'(status_o), 32'h01);
    chk("R10 irq on collision", 32'(irq_o), 1);
    tk(5'h00, 8'h01);
    chk("R10 clear alone", 32'(irq_o), 0);

    // R5 / R6 periodic with reset-on-match on channel 6
    quiet();
    wr(a_ctl(6), 32'hC9); wr(a_mat(6), 32'h3); wr(a_cnt(6), 32'h0);
    repeat (3) tk(5'h01, 0);
    chk("R4 ch6 match", 32'(status_o), 32'h04);
    rd(a_cnt(6), v); chk("R5 reset to zero", v, 0);
    tk(5'h00, 8'h04);
    repeat (3) tk(5'h01, 0);
    chk("R6 periodic second", 32'(status_o), 32'h04);
    tk(5'h00, 8'h04);
    // one-shot
    wr(a_ctl(6), 32'h89); wr(a_cnt(6), 32'h0);
    repeat (3) tk(5'h01, 0);
    chk("R6 oneshot first", 32'(status_o), 32'h04);
    tk(5'h00, 8'h04);
    repeat (3) tk(5'h01, 0);
    chk("R6 oneshot disarmed", 32'(status_o), 0);
    rd(a_cnt(6), v); chk("R6 counter ran", v, 3);
    wr(a_mat(6), 32'h5);
    repeat (2) tk(5'h01, 0);
    chk("R6 rearm by match write", 32'(status_o), 32'h04);

    // R7 group sharing
    quiet();
    wr(a_ctl(4), 32'h1); wr(a_cnt(4), 32'h40); wr(a_mat(4), 32'h0);
    wr(a_ctl(5), 32'h1); wr(a_cnt(5), 32'h7); wr(a_mat(5), 32'h42);
    repeat (2) tk(5'h01, 0);
    chk("R7 shared match ch5", 32'(status_o), 32'h02);
    rd(a_cnt(5), v); chk("R7 non-leader holds", v, 7);
    tk(5'h00, 8'hFF);
    wr(a_ctl(4), 32'h0);
    wr(a_ctl(8), 32'h1); wr(a_cnt(8), 32'h10); wr(a_mat(8), 32'h0);
    wr(a_ctl(9), 32'h0); wr(a_mat(9), 32'h11);
    tk(5'h01, 0);
    chk("R7 pair ch9 on ch8", 32'(status_o), 32'h20);

    // R8 control masking and halt
    quiet();
    wr(a_ctl(4), 32'h3C1); rd(a_ctl(4), v); chk("R8 mask low group", v, 32'hC1);
    wr(a_ctl(8), 32'h3C1); rd(a_ctl(8), v); chk("R8 keep ten bits", v, 32'h3C1);
    wr(a_ctl(4), 32'h0);
    wr(a_ctl(8), 32'h181); wr(a_cnt(8), 32'h50);
    repeat (2) tk(5'h01, 0);
    rd(a_cnt(8), v); chk("R8 halted", v, 32'h50);
    wr(a_ctl(8), 32'h081);
    tk(5'h01, 0);
    rd(a_cnt(8), v); chk("R8 released", v, 32'h51);

    // R9 snapshot
    quiet();
    wr(a_cnt(8), 32'hABCD);
    wr(a_ctl(9), 32'h280);
    rd(a_cnt(9), v);
    rd(8'h20, v); chk("R9 snapshot ch8", v, 32'hABCD);
    wr(a_cnt(10), 32'h55); wr(a_ctl(11), 32'h080);
    rd(a_cnt(11), v);
    rd(8'h20, v); chk("R9 no snapshot without bit9", v, 32'hABCD);
    wr(a_ctl(11), 32'h280);
    rd(a_cnt(11), v);
    rd(8'h20, v); chk("R9 snapshot ch10", v, 32'h55);

    // R11 unmapped and idle
    rd(8'h24, v); chk("R11 unmapped", v, 0);
    rd(8'h00, v); chk("R11 unmapped low", v, 0);
    @(negedge clk); chk("R11 idle zero", bus_rdata_o, 0);

    // R2 random sweep on channel 7 with its own counter
    quiet();
    irq_en_i = 8'h00;
    for (int it = 0; it < 16; it++) begin
      int r;
      r = int'($urandom_range(7, 0));
      wr(a_ctl(7), 32'h80 | 32'(r));
      wr(a_cnt(7), 32'h0);
      exp_c = 0;
      for (int k = 0; k < 20; k++) begin
        logic [4:0] t;
        t = 5'($urandom);
        exp_c += adv_of(r, t);
        tk(t, 0);
      end
      rd(a_cnt(7), v); chk("R2 random rate", v, 32'(exp_c));
    end

    report();
  end
endmodule